// File: doc/BRIEF.md
# Banked Register File Address Mapper

This block turns the 5-bit register operand of a data-access instruction into a location in a banked data RAM. The RAM holds sixteen banks of sixteen 8-bit registers, plus one separate bank of sixteen global registers. The block also holds the 8-bit file select pointer that the indirect and semi-direct modes use. It keeps that pointer up to date from three sources: ordinary writes that land on the pointer's own global slot, a 3-bit bank-select operation, and set/clear commands for the top bit of the pointer.

The value of the operand picks the addressing mode:

- **Indirect (operand zero):** the full pointer is the address.
- **Direct (bit 4 clear, non-zero):** the operand names a global register, and the pointer is ignored.
- **Semi-direct (bit 4 set):** the pointer's upper nibble names a banked page, and the operand's low nibble names the register inside it.

The mapper presents three things to the RAM: a global/banked select, a bank number and a register index. It also gates the RAM write strobe. It returns read data that has been corrected for the two special global slots: slot 0, the indirect port, and slot 4, the pointer itself. Every pin is a plain control or data pin. The access is combinational within the cycle, so there is no handshake and no back-pressure. Pointer updates take effect on the following access.

Top module: `fr_bank_mapper`

## Requirements
- R1: After reset the pointer `fsr_q` is 00h.
- R2: For an operand from 01h to 0Fh, `map_glob` is 1, `map_bank` is 0 and `map_reg` is operand bits 3:0, whatever the pointer holds.
- R3: For an operand from 10h to 1Fh, `map_glob` is 0, `map_bank` is pointer bits 7:4 (banks 0 to F are all reachable) and `map_reg` is operand bits 3:0. Pointer bits 3:0 have no effect.
- R4: For operand 00h with pointer 10h to FFh, `map_glob` is 0, `map_bank` is pointer bits 7:4 and `map_reg` is pointer bits 3:0.
- R5: For operand 00h with pointer 01h to 0Fh, `map_glob` is 1, `map_bank` is 0 and `map_reg` is pointer bits 3:0.
- R6: For operand 00h with pointer 00h, `rd_data` is 00h and `map_we` is 0, even when a write is requested.
- R7: An access that resolves to global slot 04h reads the pointer on `rd_data` and gives `map_we` = 0. If it is a write, it loads `acc_wdata` into the pointer at the next clock edge.
- R8: `bank_set` loads `bank_val` into pointer bits 6:4 and leaves bits 7 and 3:0 unchanged.
- R9: `hi_set` sets pointer bit 7 and `hi_clr` clears it. When both are raised, the set wins. Bits 6:0 are unchanged.
- R10: A pointer write through global slot 04h overrides `bank_set`, `hi_set` and `hi_clr` in the same cycle.
- R11: Any other access drives `map_we` = `acc_en & acc_wr` and passes `ram_rdata` to `rd_data`. With `acc_en` low, no write reaches the RAM or the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | A data access is made this cycle |
| acc_opnd | input | 5 | Register operand from the instruction |
| acc_wr | input | 1 | The access is a write |
| acc_wdata | input | 8 | Write data |
| bank_set | input | 1 | Load pointer bits 6:4 |
| bank_val | input | 3 | Value for pointer bits 6:4 |
| hi_set | input | 1 | Set pointer bit 7 |
| hi_clr | input | 1 | Clear pointer bit 7 |
| ram_rdata | input | 8 | Read data from the RAM at the mapped location |
| map_glob | output | 1 | 1 selects the global bank, 0 a numbered bank |
| map_bank | output | 4 | Numbered bank (0 when global) |
| map_reg | output | 4 | Register index inside the bank |
| map_we | output | 1 | Write strobe to the RAM |
| rd_data | output | 8 | Read data returned to the datapath |
| fsr_q | output | 8 | Current pointer value |

## Verification
The only state in the block is the pointer. A wrong pointer shows up at the very next semi-direct or indirect access: `map_bank` or `map_reg` names the wrong slot, and `fsr_q` differs directly in the cycle after the faulty update. A fault in the mode decode needs no state to appear: it shows in the same cycle as a global select on a semi-direct operand, or as a live write strobe on the null indirect port. The bench therefore reloads the pointer before every mapped operand and compares the mapping outputs within that cycle. It checks the pointer one edge after each update operation.

// File: rtl/fr_map_pkg.sv
package fr_map_pkg;
  // Addressing mode chosen by the operand value
  typedef enum logic [1:0] {
    AM_IND  = 2'd0,
    AM_DIR  = 2'd1,
    AM_SEMI = 2'd2
  } am_e;
endpackage

// File: rtl/fr_mode_dec.sv
module fr_mode_dec
  import fr_map_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W:0] opnd,
  output am_e            mode
);
  always_comb begin
    if (opnd == '0)          mode = AM_IND;
    else if (opnd[IDX_W])    mode = AM_SEMI;
    else                     mode = AM_DIR;
  end
endmodule

// File: rtl/fr_sel_reg.sv
module fr_sel_reg #(
  parameter int IDX_W  = 4,
  parameter int BANK_W = 4,
  localparam int FSR_W = IDX_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FSR_W-1:0]  wr_val,
  input  logic              bank_set,
  input  logic [BANK_W-2:0] bank_val,
  input  logic              hi_set,
  input  logic              hi_clr,
  output logic [FSR_W-1:0]  fsr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q <= '0;
    end else if (wr_en) begin
      // full pointer write through its mapped slot wins
      fsr_q <= wr_val;
    end else begin
      if (bank_set) fsr_q[FSR_W-2:IDX_W] <= bank_val;
      if (hi_set)      fsr_q[FSR_W-1] <= 1'b1;
      else if (hi_clr) fsr_q[FSR_W-1] <= 1'b0;
    end
  end
endmodule

// File: rtl/fr_addr_gen.sv
module fr_addr_gen
  import fr_map_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int BANK_W = 4,
  localparam int FSR_W = IDX_W + BANK_W
) (
  input  am_e               mode,
  input  logic [IDX_W:0]    opnd,
  input  logic [FSR_W-1:0]  fsr,
  output logic              glob,
  output logic [BANK_W-1:0] bank,
  output logic [IDX_W-1:0]  idx,
  output logic              nul
);
  logic [BANK_W-1:0] fsr_bank;
  logic [IDX_W-1:0]  fsr_idx;

  assign fsr_bank = fsr[FSR_W-1:IDX_W];
  assign fsr_idx  = fsr[IDX_W-1:0];

  always_comb begin
    glob = 1'b1;
    bank = '0;
    idx  = opnd[IDX_W-1:0];
    nul  = 1'b0;
    case (mode)
      AM_DIR: begin
        // globals only, pointer not consulted
      end
      AM_SEMI: begin
        glob = 1'b0;
        bank = fsr_bank;
      end
      AM_IND: begin
        idx = fsr_idx;
        if (fsr_bank != '0) begin
          glob = 1'b0;
          bank = fsr_bank;
        end
        nul = (fsr == '0);
      end
      default: begin
        nul = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fr_bank_mapper.sv
module fr_bank_mapper
  import fr_map_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int BANK_W   = 4,
  parameter int FSR_PORT = 4,
  localparam int FSR_W   = IDX_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic [IDX_W:0]    acc_opnd,
  input  logic              acc_wr,
  input  logic [FSR_W-1:0]  acc_wdata,
  input  logic              bank_set,
  input  logic [BANK_W-2:0] bank_val,
  input  logic              hi_set,
  input  logic              hi_clr,
  input  logic [FSR_W-1:0]  ram_rdata,
  output logic              map_glob,
  output logic [BANK_W-1:0] map_bank,
  output logic [IDX_W-1:0]  map_reg,
  output logic              map_we,
  output logic [FSR_W-1:0]  rd_data,
  output logic [FSR_W-1:0]  fsr_q
);
  localparam logic [IDX_W-1:0] PORT_IDX = IDX_W'(FSR_PORT);

  am_e  mode;
  logic nul;
  logic port_sel;
  logic fsr_wr;

  fr_mode_dec #(.IDX_W(IDX_W)) u_dec (
    .opnd (acc_opnd),
    .mode (mode)
  );

  fr_addr_gen #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_gen (
    .mode (mode),
    .opnd (acc_opnd),
    .fsr  (fsr_q),
    .glob (map_glob),
    .bank (map_bank),
    .idx  (map_reg),
    .nul  (nul)
  );

  // the pointer lives here, not in the RAM
  assign port_sel = map_glob && (map_reg == PORT_IDX);
  assign fsr_wr   = acc_en && acc_wr && port_sel;
  assign map_we   = acc_en && acc_wr && !nul && !port_sel;

  always_comb begin
    if (nul)           rd_data = '0;
    else if (port_sel) rd_data = fsr_q;
    else               rd_data = ram_rdata;
  end

  fr_sel_reg #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_fsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fsr_wr),
    .wr_val   (acc_wdata),
    .bank_set (bank_set),
    .bank_val (bank_val),
    .hi_set   (hi_set),
    .hi_clr   (hi_clr),
    .fsr_q    (fsr_q)
  );
endmodule

// File: rtl/fr_bank_mapper_chk.sv
module fr_bank_mapper_chk #(
  parameter int IDX_W    = 4,
  parameter int BANK_W   = 4,
  parameter int FSR_PORT = 4,
  localparam int FSR_W   = IDX_W + BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic [IDX_W:0]    acc_opnd,
  input logic              acc_wr,
  input logic [FSR_W-1:0]  acc_wdata,
  input logic              bank_set,
  input logic [BANK_W-2:0] bank_val,
  input logic              hi_set,
  input logic              hi_clr,
  input logic [FSR_W-1:0]  ram_rdata,
  input logic              map_glob,
  input logic [BANK_W-1:0] map_bank,
  input logic [IDX_W-1:0]  map_reg,
  input logic              map_we,
  input logic [FSR_W-1:0]  rd_data,
  input logic [FSR_W-1:0]  fsr_q
);
  logic wr_port;
  logic any_op;
  assign wr_port = acc_en && acc_wr && map_glob && (map_reg == IDX_W'(FSR_PORT));
  assign any_op  = wr_port || bank_set || hi_set || hi_clr;

  // R2
  a_r2_direct_global: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_opnd != '0 && !acc_opnd[IDX_W]) |-> (map_glob && map_reg == acc_opnd[IDX_W-1:0]));

  // R3
  a_r3_semi_never_global: assert property (@(posedge clk) disable iff (!rst_n)
    acc_opnd[IDX_W] |-> (!map_glob && map_bank == fsr_q[FSR_W-1:IDX_W]));

  // R4
  a_r4_ind_skips_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_opnd == '0 && !map_glob) |-> (map_bank != '0));

  // R6
  a_r6_null_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_opnd == '0 && fsr_q == '0) |-> (!map_we && rd_data == '0));

  // R7
  a_r7_port_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_port |=> (fsr_q == $past(acc_wdata)));

  // R8
  a_r8_bank_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_set && !hi_set && !hi_clr && !wr_port) |=>
      (fsr_q[FSR_W-1] == $past(fsr_q[FSR_W-1]) &&
       fsr_q[FSR_W-2:IDX_W] == $past(bank_val) &&
       fsr_q[IDX_W-1:0] == $past(fsr_q[IDX_W-1:0])));

  // R9
  a_r9_top_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_set && !wr_port) |=> fsr_q[FSR_W-1]);

  // R11
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !any_op |=> $stable(fsr_q));

  a_r11_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> !map_we);
endmodule

bind fr_bank_mapper fr_bank_mapper_chk #(
  .IDX_W(IDX_W), .BANK_W(BANK_W), .FSR_PORT(FSR_PORT)
) u_chk (.*);

// File: tb/fr_bank_mapper_tb_top.sv
module fr_bank_mapper_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_en;
  logic [4:0] acc_opnd;
  logic       acc_wr;
  logic [7:0] acc_wdata;
  logic       bank_set;
  logic [2:0] bank_val;
  logic       hi_set;
  logic       hi_clr;
  logic [7:0] ram_rdata;
  logic       map_glob;
  logic [3:0] map_bank;
  logic [3:0] map_reg;
  logic       map_we;
  logic [7:0] rd_data;
  logic [7:0] fsr_q;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  fr_bank_mapper dut_i (.*);

  // {pointer, operand, glob, bank, reg}
  localparam int NV = 10;
  localparam logic [21:0] VEC [NV] = '{
    {8'h35, 5'h07, 1'b1, 4'h0, 4'h7},  // R2 pointer ignored
    {8'hF0, 5'h0F, 1'b1, 4'h0, 4'hF},  // R2
    {8'h35, 5'h1A, 1'b0, 4'h3, 4'hA},  // R3
    {8'h0F, 5'h12, 1'b0, 4'h0, 4'h2},  // R3 bank 0 reachable
    {8'hFF, 5'h10, 1'b0, 4'hF, 4'h0},  // R3 low nibble ignored
    {8'hA7, 5'h1C, 1'b0, 4'hA, 4'hC},  // R3
    {8'h35, 5'h00, 1'b0, 4'h3, 4'h5},  // R4
    {8'h10, 5'h00, 1'b0, 4'h1, 4'h0},  // R4
    {8'h0B, 5'h00, 1'b1, 4'h0, 4'hB},  // R5
    {8'h01, 5'h00, 1'b1, 4'h0, 4'h1}   // R5
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    acc_en = 0; acc_opnd = '0; acc_wr = 0; acc_wdata = '0;
    bank_set = 0; bank_val = '0; hi_set = 0; hi_clr = 0;
  endtask

  // load pointer through global slot 04h (direct operand 04h)
  task automatic load_ptr(input logic [7:0] v);
    @(negedge clk);
    idle();
    acc_en = 1; acc_opnd = 5'h04; acc_wr = 1; acc_wdata = v;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle();
    ram_rdata = 8'h5A;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset pointer", fsr_q, 8'h00);

    // R6 null indirect port right after reset
    @(negedge clk);
    acc_en = 1; acc_opnd = 5'h00; acc_wr = 1; acc_wdata = 8'hEE;
    #1;
    chk("R6 null read", rd_data, 8'h00);
    chk("R6 null write", map_we, 0);
    @(negedge clk);
    idle();
    #1;
    chk("R6 pointer untouched", fsr_q, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] p;
      logic [4:0] op;
      string tag;
      p  = VEC[i][21:14];
      op = VEC[i][13:9];
      tag = (op == 0) ? ((p[7:4] == 0) ? "R5" : "R4") : (op[4] ? "R3" : "R2");
      load_ptr(p);
      acc_en = 1; acc_opnd = op;
      #1;
      chk({tag, " glob"}, map_glob, VEC[i][8]);
      chk({tag, " bank"}, map_bank, VEC[i][7:4]);
      chk({tag, " reg"},  map_reg,  VEC[i][3:0]);
    end

    // R7 slot 04h read returns pointer, write blocked from RAM
    load_ptr(8'h3C);
    acc_en = 1; acc_opnd = 5'h04; acc_wr = 0;
    #1;
    chk("R7 read pointer", rd_data, 8'h3C);
    @(negedge clk);
    acc_wr = 1; acc_wdata = 8'h91;
    #1;
    chk("R7 no ram write", map_we, 0);
    chk("R7 old value same cycle", fsr_q, 8'h3C);
    @(negedge clk);
    idle();
    #1;
    chk("R7 loaded next edge", fsr_q, 8'h91);

    // R7 indirect through pointer 04h
    load_ptr(8'h04);
    acc_en = 1; acc_opnd = 5'h00; acc_wr = 1; acc_wdata = 8'h77;
    #1;
    chk("R7 indirect no ram write", map_we, 0);
    @(negedge clk);
    idle();
    #1;
    chk("R7 indirect loads pointer", fsr_q, 8'h77);

    // R11 ordinary write and read pass-through
    @(negedge clk);
    acc_en = 1; acc_opnd = 5'h08; acc_wr = 1; ram_rdata = 8'hC3;
    #1;
    chk("R11 ram write", map_we, 1);
    chk("R11 read pass", rd_data, 8'hC3);
    // R11 disabled access: no ram write, pointer kept
    @(negedge clk);
    acc_en = 0; acc_opnd = 5'h04; acc_wr = 1; acc_wdata = 8'h00;
    #1;
    chk("R11 idle no write", map_we, 0);
    @(negedge clk);
    idle();
    #1;
    chk("R11 idle pointer kept", fsr_q, 8'h77);

    // R8 bank select keeps bit 7 and low nibble
    load_ptr(8'h8C);
    bank_set = 1; bank_val = 3'd2;
    @(negedge clk);
    idle();
    #1;
    chk("R8 bank select", fsr_q, 8'hAC);
    load_ptr(8'h05);
    bank_set = 1; bank_val = 3'd7;
    @(negedge clk);
    idle();
    #1;
    chk("R8 bank select low half", fsr_q, 8'h75);

    // R9 top bit
    hi_set = 1;
    @(negedge clk);
    idle();
    #1;
    chk("R9 set top", fsr_q, 8'hF5);
    hi_clr = 1;
    @(negedge clk);
    idle();
    #1;
    chk("R9 clear top", fsr_q, 8'h75);
    hi_set = 1; hi_clr = 1;
    @(negedge clk);
    idle();
    #1;
    chk("R9 set wins", fsr_q, 8'hF5);
    hi_clr = 1; bank_set = 1; bank_val = 3'd1;
    @(negedge clk);
    idle();
    #1;
    chk("R9 with bank select", fsr_q, 8'h15);

    // R10 port write overrides the other updates
    load_ptr(8'h11);
    acc_en = 1; acc_opnd = 5'h04; acc_wr = 1; acc_wdata = 8'h66;
    bank_set = 1; bank_val = 3'd7; hi_set = 1;
    @(negedge clk);
    idle();
    #1;
    chk("R10 write priority", fsr_q, 8'h66);

    // R1 reset again from a non-zero pointer
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset clears", fsr_q, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule